// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a two-part virtual address, a segment number and a word offset within that segment, into a flat physical address. Each process has a descriptor table in physical memory with one descriptor word per segment. Two register inputs locate the table: its physical base and the highest segment number the table covers. For every request the block reads the descriptor for the segment through a memory read port with one cycle of latency. It then checks the descriptor against the request and returns either the physical address or a fault code.

Each descriptor holds the segment's physical base, the highest valid offset within the segment, three permission bits and a not-present flag. The four checks run in a fixed priority order, and the first check that fails sets the reported fault code. Only one translation is in flight at a time. A response follows every accepted request at a fixed latency.

Top module: `seg_xlat`

## Requirements
- R1: `req_ready` is high only when no translation is in flight. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `resp_valid` is high for exactly one cycle, in the second cycle after the accepting edge. `req_ready` returns high in the cycle after that response.
- R2: In the accepting cycle, when the segment number is within the table, the block asserts `desc_rd_en` with `desc_rd_addr` equal to `dbr_base + req_seg`. It expects the descriptor on `desc_rd_data` in the following cycle. No read is issued for a segment beyond the table.
- R3: A segment number greater than `dbr_limit` faults with code 1. A segment number equal to `dbr_limit` passes this check.
- R4: A descriptor with its not-present flag (bit 0) set faults with code 2.
- R5: An offset greater than the descriptor's offset limit (bits OFF_W+3 down to 4) faults with code 3. An offset equal to the limit passes this check.
- R6: Access codes are read=0, write=1 and execute=2. Each needs its own permission bit in the descriptor: read is bit 1, write is bit 2 and execute is bit 3. If the needed bit is clear, the request faults with code 4.
- R7: Access code 3 is reserved and always faults with code 4.
- R8: The checks take priority in this order: table bound (1), not-present (2), offset bound (3), access (4). Only the code of the first failing check is reported.
- R9: On success `resp_fault` is 0 and `resp_paddr` equals the descriptor base (the top PA_W bits) plus the offset, modulo 2^PA_W. On any fault `resp_paddr` is 0.
- R10: After reset `req_ready` is high and both `resp_valid` and `desc_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Word offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| dbr_base | input | PA_W | Physical base of the descriptor table |
| dbr_limit | input | SEG_W | Highest segment number held in the table |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_rd_addr | output | PA_W | Descriptor read address |
| desc_rd_data | input | PA_W+OFF_W+4 | Descriptor word, valid one cycle after the strobe |
| resp_valid | output | 1 | Result valid (one-cycle pulse) |
| resp_fault | output | 3 | 0 success, 1 table bound, 2 not present, 3 offset bound, 4 access |
| resp_paddr | output | PA_W | Translated physical address, 0 on fault |

## Verification
The translation is exercised with segment numbers and offsets placed exactly on their limits and one step beyond them. This separates inclusive bounds from exclusive ones. Each access type is sent against descriptors that grant a single permission, none or all of them, and the reserved code is also sent. This shows that the needed permission bit is decoded and that granted bits are not confused with one another. Descriptors that fail several checks at once show which fault code wins. A base near the top of the address space shows wrap-around addition. The read strobe and read address are observed for each request, so any read issued for an out-of-table segment is caught.

// File: rtl/seg_xlat_pkg.sv
// Shared encodings for the segment translator: access types, fault codes
// and the control state. Assumes no parameterization of these encodings.
package seg_xlat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_TABLE  = 3'd1,
        FLT_ABSENT = 3'd2,
        FLT_OFFSET = 3'd3,
        FLT_RIGHTS = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } state_e;
endpackage

// File: rtl/seg_xlat_check.sv
// Combinational descriptor check. Splits the descriptor word into its base,
// offset limit, permission bits and not-present flag. Applies the checks in
// priority order and forms the physical address. Assumes the table-bound
// result was computed earlier and is passed in as tbl_ok.
module seg_xlat_check
    import seg_xlat_pkg::*;
#(
    parameter int PA_W  = 16,
    parameter int OFF_W = 8,
    localparam int DESC_W = PA_W + OFF_W + 4
) (
    input  logic [DESC_W-1:0] desc_word,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        acc,
    input  logic              tbl_ok,
    output logic [2:0]        fault,
    output logic [PA_W-1:0]   paddr
);
    logic [PA_W-1:0]  seg_base;
    logic [OFF_W-1:0] seg_lim;
    logic [2:0]       rights;
    logic             absent;
    logic [2:0]       need;
    logic             rights_ok;
    fault_e           code;

    // Field extraction from the descriptor word.
    assign seg_base = desc_word[DESC_W-1 -: PA_W];
    assign seg_lim  = desc_word[OFF_W+3:4];
    assign rights   = desc_word[3:1];
    assign absent   = desc_word[0];

    // Map the access type onto the permission bit it needs.
    always_comb begin
        need      = 3'b000;
        rights_ok = 1'b0;
        case (acc_e'(acc))
            ACC_READ:  need = 3'b001;
            ACC_WRITE: need = 3'b010;
            ACC_EXEC:  need = 3'b100;
            default:   need = 3'b000;
        endcase
        if (acc_e'(acc) != ACC_RSVD)
            rights_ok = ((need & ~rights) == 3'b000);
    end

    // Priority chain: the first failing check names the fault.
    always_comb begin
        if (!tbl_ok)             code = FLT_TABLE;
        else if (absent)         code = FLT_ABSENT;
        else if (off > seg_lim)  code = FLT_OFFSET;
        else if (!rights_ok)     code = FLT_RIGHTS;
        else                     code = FLT_NONE;
    end

    assign fault = code;
    assign paddr = (code == FLT_NONE) ? seg_base + PA_W'(off) : '0;
endmodule

// File: rtl/seg_xlat_ctrl.sv
// Request sequencing. Accepts one request while idle and launches the
// descriptor read in the same cycle, unless the segment is beyond the table.
// Holds the offset and access type while the descriptor arrives, then
// registers the check result as a one-cycle response. Assumes the memory
// returns data exactly one cycle after the read strobe.
module seg_xlat_ctrl
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int PA_W  = 16,
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_acc,
    input  logic [PA_W-1:0]  dbr_base,
    input  logic [SEG_W-1:0] dbr_limit,
    output logic             desc_rd_en,
    output logic [PA_W-1:0]  desc_rd_addr,
    output logic [OFF_W-1:0] hold_off,
    output logic [1:0]       hold_acc,
    output logic             hold_tbl_ok,
    input  logic [2:0]       chk_fault,
    input  logic [PA_W-1:0]  chk_paddr,
    output logic             resp_valid,
    output logic [2:0]       resp_fault,
    output logic [PA_W-1:0]  resp_paddr
);
    state_e state;
    logic   accept;
    logic   in_table;

    assign req_ready    = (state == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign in_table     = (req_seg <= dbr_limit);
    assign desc_rd_en   = accept && in_table;
    assign desc_rd_addr = dbr_base + PA_W'(req_seg);
    assign resp_valid   = (state == ST_RESP);

    // State sequence: idle -> wait for descriptor -> respond -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept) state <= ST_WAIT;
                ST_WAIT: state <= ST_RESP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Capture the request fields that the check needs a cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_off    <= '0;
            hold_acc    <= '0;
            hold_tbl_ok <= 1'b0;
        end else if (accept) begin
            hold_off    <= req_off;
            hold_acc    <= req_acc;
            hold_tbl_ok <= in_table;
        end
    end

    // Register the check outcome as the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_fault <= '0;
            resp_paddr <= '0;
        end else if (state == ST_WAIT) begin
            resp_fault <= chk_fault;
            resp_paddr <= chk_paddr;
        end
    end
endmodule

// File: rtl/seg_xlat.sv
// Top of the segment descriptor address translator. Joins the request
// sequencer to the descriptor check. Assumes dbr_base and dbr_limit stay
// stable while a translation is in flight.
module seg_xlat #(
    parameter int SEG_W = 4,
    parameter int PA_W  = 16,
    parameter int OFF_W = 8,
    localparam int DESC_W = PA_W + OFF_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    input  logic [PA_W-1:0]   dbr_base,
    input  logic [SEG_W-1:0]  dbr_limit,
    output logic              desc_rd_en,
    output logic [PA_W-1:0]   desc_rd_addr,
    input  logic [DESC_W-1:0] desc_rd_data,
    output logic              resp_valid,
    output logic [2:0]        resp_fault,
    output logic [PA_W-1:0]   resp_paddr
);
    logic [OFF_W-1:0] hold_off;
    logic [1:0]       hold_acc;
    logic             hold_tbl_ok;
    logic [2:0]       chk_fault;
    logic [PA_W-1:0]  chk_paddr;

    seg_xlat_ctrl #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .dbr_base(dbr_base), .dbr_limit(dbr_limit),
        .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
        .hold_off(hold_off), .hold_acc(hold_acc), .hold_tbl_ok(hold_tbl_ok),
        .chk_fault(chk_fault), .chk_paddr(chk_paddr),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    seg_xlat_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
        .desc_word(desc_rd_data), .off(hold_off), .acc(hold_acc),
        .tbl_ok(hold_tbl_ok), .fault(chk_fault), .paddr(chk_paddr)
    );
endmodule

// File: rtl/seg_xlat_chk.sv
// Port-level protocol properties for seg_xlat, attached by bind.
module seg_xlat_chk #(
    parameter int SEG_W = 4,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W-1:0] dbr_limit,
    input logic             desc_rd_en,
    input logic             resp_valid,
    input logic [2:0]       resp_fault,
    input logic [PA_W-1:0]  resp_paddr
);
    logic accept;
    assign accept = req_valid && req_ready;

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    p_resp_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 resp_valid);
    p_resp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
    p_read_in_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |-> (accept && req_seg <= dbr_limit));
    p_table_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_seg > dbr_limit) |=> ##1 (resp_fault == 3'd1));
    p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_fault <= 3'd4));
    p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 3'd0) |-> (resp_paddr == '0));
endmodule

bind seg_xlat seg_xlat_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_seg(req_seg), .dbr_limit(dbr_limit), .desc_rd_en(desc_rd_en),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
);

// File: tb/sim_seg_xlat.sv
module sim_seg_xlat;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W = 4, PA_W = 16, OFF_W = 8;
    localparam int DESC_W = PA_W + OFF_W + 4;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [SEG_W-1:0] req_seg = 0, dbr_limit = 4'd5;
    logic [OFF_W-1:0] req_off = 0;
    logic [1:0] req_acc = 0;
    logic [PA_W-1:0] dbr_base = 16'd8;
    logic desc_rd_en;
    logic [PA_W-1:0] desc_rd_addr;
    logic [DESC_W-1:0] desc_rd_data;
    logic resp_valid;
    logic [2:0] resp_fault;
    logic [PA_W-1:0] resp_paddr;

    logic [DESC_W-1:0] mem [64];
    logic [DESC_W-1:0] rd_q = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlat #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .dbr_base(dbr_base), .dbr_limit(dbr_limit),
        .desc_rd_en(desc_rd_en), .desc_rd_addr(desc_rd_addr),
        .desc_rd_data(desc_rd_data), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_paddr(resp_paddr)
    );

    // One-cycle-latency descriptor memory.
    always @(posedge clk) if (desc_rd_en) rd_q <= mem[desc_rd_addr[5:0]];
    assign desc_rd_data = rd_q;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DESC_W-1:0] mk(input logic [15:0] b, input logic [7:0] l,
                                              input logic [2:0] r, input logic a);
        return {b, l, r, a};
    endfunction

    // Drive one request and check read strobe, latency and result.
    task automatic xlat(input logic [3:0] s, input logic [7:0] i, input logic [1:0] a,
                        input logic [2:0] ef, input logic [15:0] epa, input string req);
        logic exp_rd;
        exp_rd = (s <= dbr_limit);
        @(negedge clk);
        chk(req_ready == 1, "R1", "ready when idle", 32'(req_ready), 1);
        req_valid = 1; req_seg = s; req_off = i; req_acc = a;
        #1;
        chk(desc_rd_en == exp_rd, "R2", "read strobe", 32'(desc_rd_en), 32'(exp_rd));
        if (exp_rd)
            chk(desc_rd_addr == dbr_base + 16'(s), "R2", "read address",
                32'(desc_rd_addr), 32'(dbr_base + 16'(s)));
        @(negedge clk);
        req_valid = 0;
        chk(!resp_valid && !req_ready, "R1", "busy, no response yet",
            32'({resp_valid, req_ready}), 0);
        @(negedge clk);
        chk(resp_valid == 1, "R1", "response cycle", 32'(resp_valid), 1);
        chk(resp_fault == ef, req, "fault code", 32'(resp_fault), 32'(ef));
        chk(resp_paddr == epa, (ef == 0) ? req : "R9", "physical address",
            32'(resp_paddr), 32'(epa));
        @(negedge clk);
        chk(!resp_valid && req_ready, "R1", "pulse ends, ready again",
            32'({resp_valid, req_ready}), 32'b01);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1, "R10", "ready after reset", 32'(req_ready), 1);
        chk(resp_valid == 0, "R10", "no response after reset", 32'(resp_valid), 0);
        chk(desc_rd_en == 0, "R10", "no read after reset", 32'(desc_rd_en), 0);
    endtask

    task automatic t_success;
        xlat(0, 8'h05, 0, 0, 16'h1005, "R9");
        xlat(0, 8'h3F, 1, 0, 16'h103F, "R5");   // offset equal to limit allowed
        xlat(1, 8'h10, 2, 0, 16'h2010, "R6");
        xlat(3, 8'h80, 1, 0, 16'h3080, "R6");
        xlat(5, 8'h20, 0, 0, 16'h0010, "R9");   // wrap; seg equal to table limit
    endtask

    task automatic t_table;
        xlat(6, 8'h00, 0, 1, 0, "R3");
        xlat(15, 8'h00, 2, 1, 0, "R3");
    endtask

    task automatic t_absent;
        xlat(2, 8'h00, 0, 2, 0, "R4");
    endtask

    task automatic t_offset;
        xlat(0, 8'h40, 0, 3, 0, "R5");
        xlat(1, 8'hFF, 2, 3, 0, "R5");
    endtask

    task automatic t_access;
        xlat(0, 8'h01, 2, 4, 0, "R6");
        xlat(1, 8'h01, 0, 4, 0, "R6");
        xlat(1, 8'h01, 1, 4, 0, "R6");
        xlat(5, 8'h00, 1, 4, 0, "R6");
        xlat(3, 8'h01, 3, 4, 0, "R7");
    endtask

    task automatic t_priority;
        xlat(2, 8'hFF, 3, 2, 0, "R8");   // absent beats offset and access
        xlat(4, 8'h06, 1, 3, 0, "R8");   // offset beats access
        xlat(4, 8'h05, 0, 4, 0, "R8");
        xlat(7, 8'hFF, 3, 1, 0, "R8");   // table bound beats all
    endtask

    initial begin
        for (int k = 0; k < 64; k++) mem[k] = mk(16'hDEAD, 8'h00, 3'b111, 1'b1);
        mem[8]  = mk(16'h1000, 8'h3F, 3'b011, 1'b0);
        mem[9]  = mk(16'h2000, 8'h10, 3'b100, 1'b0);
        mem[10] = mk(16'h5000, 8'hFF, 3'b111, 1'b1);
        mem[11] = mk(16'h3000, 8'hFF, 3'b111, 1'b0);
        mem[12] = mk(16'h4000, 8'h05, 3'b000, 1'b0);
        mem[13] = mk(16'hFFF0, 8'h20, 3'b001, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_success();
        t_table();
        t_absent();
        t_offset();
        t_access();
        t_priority();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule